// File: doc/BRIEF.md
# Segmented Pulse-Train Sequencer

This block drives one two-level output whose meaning lies entirely in how long each high and low stretch lasts. A small table, written through a plain register port, holds up to eight segments. Each segment describes a high stretch of some number of counts, then a low stretch of some number of counts, and how many times that pair repeats. Once started, the block walks the table in index order and emits every segment directly after the one before it, so the output is one continuous stream with no idle slot at any boundary.

Counting is paced by `tick`, a single-cycle enable strobe that the surrounding logic derives from an external clock or from a divided system clock. Each strobe emits one output slot. A level `run` input starts and stops generation. A start is recognised when `run` is seen high on a strobe after being seen low on the previous strobe. This gives a start instant that is exact to one strobe period. When the final slot of the final segment has been shown for a full strobe period, the output drops, `done` pulses once, and the block goes idle.

Top module: `pulse_train_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `pulseOut`, `busy` and `done` are all low.
- R2: A start happens on a clock edge where `tick` is high and `run` is high, and `run` was low at the previous `tick`. On that edge `busy` goes high while `pulseOut` stays low. The first output slot appears on the next `tick` edge, so the latency from start to output is exactly one strobe period.
- R3: Each table entry plays as its high count of high slots, then its low count of low slots, with that pair repeated the entry's repeat count of times. One slot lasts from one `tick` edge to the next.
- R4: Entries play in rising index order and back to back, with no extra slot between them. Play stops after the first entry whose last-marker bit is set, and entry 7 always ends the list. Entries after the stopping entry are never played.
- R5: A zero count never stalls the stream. A zero high count leaves only the low stretch in each repeat, and a zero low count leaves only the high stretch. A zero repeat count, or a zero high count together with a zero low count, removes the entry and uses up no slot.
- R6: On the `tick` edge after the final slot, `pulseOut` goes low, `busy` goes low, and `done` goes high for exactly one clock cycle.
- R7: A `tick` edge with `run` low while `busy` is high halts generation. `pulseOut` and `busy` go low on that edge, and `done` stays low.
- R8: After `done`, a `run` that stays high does not restart the sequencer. A new start needs `run` to be seen low at a `tick` and then high at a later `tick`.
- R9: When no entry up to the stopping entry has any slots, a start raises `busy`, `pulseOut` never goes high, and `done` pulses on the next `tick` edge.
- R10: `pulseOut` and `busy` change only on clock edges where `tick` is high. The gap between strobes may be any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe; one output slot per strobe |
| run | input | 1 | Start/stop level, sampled on strobes |
| wrEn | input | 1 | Table write enable |
| wrAddr | input | 3 | Table entry index to write |
| wrHigh | input | 16 | High count of the entry being written |
| wrLow | input | 16 | Low count of the entry being written |
| wrRep | input | 16 | Repeat count of the entry being written |
| wrLast | input | 1 | Marks the entry being written as the final one |
| pulseOut | output | 1 | Generated waveform |
| busy | output | 1 | High from start until completion or stop |
| done | output | 1 | One-cycle pulse when the final slot has finished |

## Verification
The hardest situation to reach from the ports is a chain of collapsed entries. In such a chain, zero-repeat entries, entries with both counts zero, and high-only or low-only entries sit next to each other and next to the stopping entry. The sequencer must then skip several entries in one step, with no lost or extra slot. A directed table places these cases side by side. Random tables draw every count from a range that includes zero and place the last marker at a random index, so skips across the boundary and fully empty tables come up often. Random gaps between strobes exercise the rule that nothing moves without a strobe.

// File: rtl/pts_pkg.sv
package pts_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // place cursor on first playable slot
    logic step;   // emit current slot and advance
    logic clear;  // force output low
  } seqCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seqState_t;

endpackage

// File: rtl/pts_seek.sv
// Finds the lowest candidate index at or above fromIdx.
module pts_seek #(
  parameter int NUM_SEG = 8,
  parameter int IDX_W   = $clog2(NUM_SEG)
) (
  input  logic [NUM_SEG-1:0] cand,
  input  logic [IDX_W:0]     fromIdx,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  localparam int FW = IDX_W + 1;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SEG - 1; i >= 0; i--) begin
      if (cand[i] && (FW'(i) >= fromIdx)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pts_ctrl.sv
module pts_ctrl
  import pts_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    run,
  input  logic    startFound,
  input  logic    hasNext,
  output seqCmd_t cmd,
  output logic    busy,
  output logic    done
);
  seqState_t state, stateNxt;
  logic      runPrev;
  logic      doneNxt;

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    doneNxt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (tick && run && !runPrev) begin
          cmd.load = 1'b1;
          stateNxt = startFound ? ST_RUN : ST_DRAIN;
        end
      end
      ST_RUN: begin
        if (tick) begin
          if (!run) begin
            cmd.clear = 1'b1;
            stateNxt  = ST_IDLE;
          end else begin
            cmd.step = 1'b1;
            if (!hasNext) stateNxt = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (tick) begin
          cmd.clear = 1'b1;
          stateNxt  = ST_IDLE;
          doneNxt   = run;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      runPrev <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
      if (tick) runPrev <= run;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pts_datapath.sv
module pts_datapath
  import pts_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int CNT_W   = 16,
  parameter int IDX_W   = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [CNT_W-1:0] wrHigh,
  input  logic [CNT_W-1:0] wrLow,
  input  logic [CNT_W-1:0] wrRep,
  input  logic             wrLast,
  input  seqCmd_t          cmd,
  output logic             startFound,
  output logic             hasNext,
  output logic             pulseOut
);
  logic [CNT_W-1:0] hiTbl  [NUM_SEG];
  logic [CNT_W-1:0] loTbl  [NUM_SEG];
  logic [CNT_W-1:0] repTbl [NUM_SEG];
  logic [NUM_SEG-1:0] lastTbl, effVec, inRange, cand;

  // segment table, one register set per entry
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hiTbl[g]   <= '0;
        loTbl[g]   <= '0;
        repTbl[g]  <= '0;
        lastTbl[g] <= 1'b0;
      end else if (wrEn && (wrAddr == IDX_W'(g))) begin
        hiTbl[g]   <= wrHigh;
        loTbl[g]   <= wrLow;
        repTbl[g]  <= wrRep;
        lastTbl[g] <= wrLast;
      end
    end
    assign effVec[g] = (repTbl[g] != '0) && ((hiTbl[g] != '0) || (loTbl[g] != '0));
  end

  // entries reachable before the first last-marker
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) begin
      inRange[i] = !blocked;
      blocked    = blocked | lastTbl[i];
    end
  end
  assign cand = effVec & inRange;

  // cursor: the slot to be emitted on the next step
  logic [IDX_W-1:0] segIdx;
  logic [CNT_W-1:0] repLeft, cntLeft;
  logic             phaseHigh;
  logic             pulseReg;

  logic [IDX_W-1:0] startIdx, nextIdx;
  logic             nextFound;
  logic [IDX_W:0]   nextFrom;

  assign nextFrom = {1'b0, segIdx} + 1'b1;

  pts_seek #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_seekFirst (
    .cand(cand), .fromIdx('0), .found(startFound), .idx(startIdx)
  );
  pts_seek #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_seekNext (
    .cand(cand), .fromIdx(nextFrom), .found(nextFound), .idx(nextIdx)
  );

  logic [IDX_W-1:0] nSeg;
  logic [CNT_W-1:0] nRep, nCnt;
  logic             nHigh;
  logic [CNT_W-1:0] curHi, curLo, nxHi, nxLo;

  assign curHi = hiTbl[segIdx];
  assign curLo = loTbl[segIdx];
  assign nxHi  = hiTbl[nextIdx];
  assign nxLo  = loTbl[nextIdx];

  always_comb begin
    nSeg    = segIdx;
    nRep    = repLeft;
    nHigh   = phaseHigh;
    nCnt    = cntLeft;
    hasNext = 1'b1;
    if (cntLeft > CNT_W'(1)) begin
      nCnt = cntLeft - 1'b1;
    end else if (phaseHigh && (curLo != '0)) begin
      nHigh = 1'b0;
      nCnt  = curLo;
    end else if (repLeft > CNT_W'(1)) begin
      nRep  = repLeft - 1'b1;
      nHigh = (curHi != '0);
      nCnt  = (curHi != '0) ? curHi : curLo;
    end else if (nextFound) begin
      nSeg  = nextIdx;
      nRep  = repTbl[nextIdx];
      nHigh = (nxHi != '0);
      nCnt  = (nxHi != '0) ? nxHi : nxLo;
    end else begin
      hasNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      segIdx    <= '0;
      repLeft   <= '0;
      cntLeft   <= '0;
      phaseHigh <= 1'b0;
      pulseReg  <= 1'b0;
    end else begin
      if (cmd.load) begin
        segIdx    <= startIdx;
        repLeft   <= repTbl[startIdx];
        phaseHigh <= (hiTbl[startIdx] != '0);
        cntLeft   <= (hiTbl[startIdx] != '0) ? hiTbl[startIdx] : loTbl[startIdx];
      end
      if (cmd.step) begin
        pulseReg  <= phaseHigh;
        segIdx    <= nSeg;
        repLeft   <= nRep;
        phaseHigh <= nHigh;
        cntLeft   <= nCnt;
      end
      if (cmd.clear) pulseReg <= 1'b0;
    end
  end

  assign pulseOut = pulseReg;
endmodule

// File: rtl/pulse_train_seq.sv
module pulse_train_seq
  import pts_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [CNT_W-1:0] wrHigh,
  input  logic [CNT_W-1:0] wrLow,
  input  logic [CNT_W-1:0] wrRep,
  input  logic             wrLast,
  output logic             pulseOut,
  output logic             busy,
  output logic             done
);
  seqCmd_t cmd;
  logic    startFound, hasNext;

  pts_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .startFound(startFound), .hasNext(hasNext),
    .cmd(cmd), .busy(busy), .done(done)
  );

  pts_datapath #(.NUM_SEG(NUM_SEG), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrHigh(wrHigh), .wrLow(wrLow),
    .wrRep(wrRep), .wrLast(wrLast),
    .cmd(cmd), .startFound(startFound), .hasNext(hasNext),
    .pulseOut(pulseOut)
  );
endmodule

// File: rtl/pts_checker.sv
module pts_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic run,
  input logic pulseOut,
  input logic busy,
  input logic done
);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pulseOut));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(busy));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !pulseOut));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pulseOut);

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(tick) && $past(run) && !pulseOut));
endmodule

bind pulse_train_seq pts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
  .pulseOut(pulseOut), .busy(busy), .done(done)
);

// File: tb/tb_pulse_train_seq.sv
module tb_pulse_train_seq;
  logic        clk = 1'b0;
  logic        rst_n, tick, run, wrEn, wrLast;
  logic [2:0]  wrAddr;
  logic [15:0] wrHigh, wrLow, wrRep;
  logic        pulseOut, busy, done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  int tHi [8];
  int tLo [8];
  int tRep[8];
  bit tLast[8];
  bit expBits[0:2047];
  int expLen;

  always #5 clk = ~clk;

  pulse_train_seq dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrHigh(wrHigh), .wrLow(wrLow),
    .wrRep(wrRep), .wrLast(wrLast),
    .pulseOut(pulseOut), .busy(busy), .done(done)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected slot stream computed from the bench copy of the table
  task automatic buildExpected();
    expLen = 0;
    for (int i = 0; i < 8; i++) begin
      for (int r = 0; r < tRep[i]; r++) begin
        for (int h = 0; h < tHi[i]; h++) begin expBits[expLen] = 1'b1; expLen++; end
        for (int l = 0; l < tLo[i]; l++) begin expBits[expLen] = 1'b0; expLen++; end
      end
      if (tLast[i]) break;
    end
  endtask

  task automatic writeTable();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 3'(i);
      wrHigh = 16'(tHi[i]); wrLow = 16'(tLo[i]); wrRep = 16'(tRep[i]);
      wrLast = tLast[i];
    end
    @(negedge clk);
    wrEn = 1'b0;
    buildExpected();
  endtask

  // one strobe, then gap idle cycles checking that nothing moves (R10)
  task automatic strobe(int gap);
    logic p, b;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    p = pulseOut; b = busy;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R10 out stable between strobes", int'(pulseOut), int'(p));
      check("R10 busy stable between strobes", int'(busy), int'(b));
    end
  endtask

  task automatic arm(int gap);
    run = 1'b0;
    strobe(gap);
    run = 1'b1;
    strobe(gap);
    check("R2 busy on start", int'(busy), 1);
    check("R2 output low one strobe", int'(pulseOut), 0);
  endtask

  task automatic playRun(string tag, bit randGap);
    arm(randGap ? int'($urandom_range(0, 2)) : 0);
    for (int k = 0; k < expLen; k++) begin
      strobe(randGap ? int'($urandom_range(0, 3)) : 0);
      check(tag, int'(pulseOut), int'(expBits[k]));
      check("R3 busy during play", int'(busy), 1);
      check("R6 no early done", int'(done), 0);
    end
    strobe(0);
    check("R6 output low at end", int'(pulseOut), 0);
    check("R6 done pulse", int'(done), 1);
    check("R6 idle at end", int'(busy), 0);
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);
    strobe(1);
    strobe(0);
    check("R8 no restart while run held", int'(busy), 0);
    check("R8 output stays low", int'(pulseOut), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 1'b0; run = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrHigh = '0; wrLow = '0; wrRep = '0; wrLast = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 out in reset", int'(pulseOut), 0);
    check("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out after reset", int'(pulseOut), 0);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);

    // R9: empty table
    for (int i = 0; i < 8; i++) begin tHi[i] = 0; tLo[i] = 0; tRep[i] = 0; tLast[i] = 0; end
    writeTable();
    playRun("R9 empty table", 1'b0);

    // R3 / R4: two long back-to-back segments
    tHi[0] = 14; tLo[0] = 14; tRep[0] = 9; tLast[0] = 0;
    tHi[1] = 16; tLo[1] = 16; tRep[1] = 8; tLast[1] = 1;
    tHi[2] = 3;  tLo[2] = 3;  tRep[2] = 2; tLast[2] = 0;
    writeTable();
    playRun("R4 gapless chain", 1'b0);

    // R5: zero-count corners next to each other
    tHi[0] = 0; tLo[0] = 3; tRep[0] = 2; tLast[0] = 0;
    tHi[1] = 2; tLo[1] = 0; tRep[1] = 2; tLast[1] = 0;
    tHi[2] = 5; tLo[2] = 5; tRep[2] = 0; tLast[2] = 0;
    tHi[3] = 0; tLo[3] = 0; tRep[3] = 3; tLast[3] = 0;
    tHi[4] = 1; tLo[4] = 1; tRep[4] = 1; tLast[4] = 0;
    tHi[5] = 0; tLo[5] = 0; tRep[5] = 0; tLast[5] = 1;
    tHi[6] = 4; tLo[6] = 4; tRep[6] = 4; tLast[6] = 0;
    writeTable();
    playRun("R5 zero counts skip", 1'b1);

    // R7: stop in mid stream, then a clean restart
    tHi[0] = 14; tLo[0] = 14; tRep[0] = 9; tLast[0] = 1;
    writeTable();
    arm(0);
    for (int k = 0; k < 20; k++) begin
      strobe(1);
      check("R7 pre-stop stream", int'(pulseOut), int'(expBits[k]));
    end
    run = 1'b0;
    strobe(0);
    check("R7 output low on stop", int'(pulseOut), 0);
    check("R7 idle on stop", int'(busy), 0);
    check("R7 no done on stop", int'(done), 0);
    @(negedge clk);
    check("R7 no done after stop", int'(done), 0);
    playRun("R3 restart after stop", 1'b0);

    // random tables, random strobe spacing
    for (int t = 0; t < 24; t++) begin
      for (int i = 0; i < 8; i++) begin
        tHi[i]  = int'($urandom_range(0, 5));
        tLo[i]  = int'($urandom_range(0, 5));
        tRep[i] = int'($urandom_range(0, 3));
        tLast[i] = ($urandom_range(0, 5) == 0);
      end
      writeTable();
      playRun("R3 random table", 1'b1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule